// File: doc/BRIEF.md
# Bitstream Header Section Parser

This block reads the opening bytes of a configuration bit file as they arrive on a byte stream with a valid/ready handshake. It first confirms a fixed 13-byte signature. It then walks the tagged sections that follow, looking for the section letter the caller asked for. Each section is a tag byte, a big-endian length and a payload. The walk ends in one of three ways: the requested tag is found, the search gives up (unknown tag or byte budget used up), or the signature is wrong.

A parse begins with a one-cycle start strobe while the block is idle. The block finishes with a one-cycle done pulse. At that pulse the found, error and length outputs are valid, and they stay valid until the next start. When the requested section is found, the block stops accepting bytes right after that section's length field. The upstream stream is therefore left pointing at the first payload byte, and the next consumer (for example a configuration downloader) can take over from there.

Top module: `bitHdrParser`

## Requirements
- R1: After reset, doneOut, foundOut, errOut, lenOut and inReady are all 0.
- R2: While idle, inReady stays 0 and no byte is taken. A startIn pulse in idle begins a new parse and clears foundOut, errOut and lenOut.
- R3: The first 13 accepted bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. At the first byte that differs, the parse ends with errOut=1 and foundOut=0, and that byte counts as consumed.
- R4: A tag byte outside 0x61..0x65 ('a' to 'e') is consumed and ends the parse with foundOut=0 and errOut=0.
- R5: The length after tags 0x61..0x64 is 2 bytes, most significant byte first. The length after tag 0x65 is 4 bytes, most significant byte first.
- R6: A 2-byte length above 64 is treated as 64. This applies both to the reported length and to the number of payload bytes skipped.
- R7: A 4-byte length above 307200 is treated as 307200.
- R8: When a section's tag does not match reqTag, exactly its (clamped) length in payload bytes is consumed, and the next byte is read as a tag.
- R9: After the signature, a tag byte or a payload byte is only accepted while fewer than 100 bytes (tags, length bytes and payload bytes) have been consumed. Once 100 have been consumed at such a point, the parse ends with foundOut=0 and errOut=0. Length bytes are always taken in full.
- R10: When a tag matches reqTag, the parse ends right after that section's length field with foundOut=1 and lenOut equal to the clamped length. From then on inReady stays 0 until the next start.
- R11: doneOut is high for exactly one cycle per parse. foundOut, errOut and lenOut hold their values from that pulse until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle request to begin a parse (honoured in idle) |
| reqTag | input | 8 | Section tag to search for; held stable during a parse |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Block takes the byte this cycle when inValid is high |
| doneOut | output | 1 | One-cycle end-of-parse pulse |
| foundOut | output | 1 | Requested section was located |
| errOut | output | 1 | Signature mismatch |
| lenOut | output | LEN_W | Clamped length of the located section |

## Verification
The assertions assume that reqTag holds still for the whole parse, and that a start arrives only while the block is idle and not in the same cycle as a done pulse. The stimulus meets both assumptions: it sets reqTag before each start, and it issues the next start only after the previous done pulse has been seen and several idle cycles have passed. Bytes are offered with random gaps in inValid. The data at each position stays fixed until that byte is taken, so the budget counter and the clamp checks see only well-formed handshakes.

// File: rtl/hdrPkg.sv
package hdrPkg;
  localparam int MAGIC_LEN = 13;
  localparam logic [7:0] TAG_FIRST = 8'h61;
  localparam logic [7:0] TAG_LAST  = 8'h65;
  localparam logic [7:0] TAG_WIDE  = 8'h65;

  typedef enum logic [2:0] {
    S_IDLE, S_PREF, S_TAG, S_LEN, S_EVAL, S_SKIP
  } hdrState_e;

  typedef struct packed {
    logic clr;
    logic prefAdv;
    logic tagLoad;
    logic lenShift;
    logic skipLoad;
    logic skipStep;
    logic finish;
    logic finFound;
    logic finErr;
  } hdrStb_t;

  function automatic logic [7:0] magicByte(input logic [3:0] idx);
    case (idx)
      4'd1:                         return 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8:       return 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9:       return 8'hF0;
      4'd12:                        return 8'h01;
      default:                      return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hdrPath.sv
module hdrPath import hdrPkg::*; #(
  parameter int LEN_W    = 32,
  parameter int BUDGET   = 100,
  parameter int TEXT_MAX = 64,
  parameter int BIG_MAX  = 307200
) (
  input  logic             clk,
  input  logic             rstN,
  input  hdrStb_t          stb,
  input  logic [7:0]       inData,
  input  logic [7:0]       reqTag,
  output logic             prefMatch,
  output logic             prefLast,
  output logic             tagOk,
  output logic             lenLast,
  output logic             budgetUsed,
  output logic             clampZero,
  output logic             skipLast,
  output logic             matchHit,
  output logic             doneOut,
  output logic             foundOut,
  output logic             errOut,
  output logic [LEN_W-1:0] lenOut
);
  localparam int CNT_W = $clog2(BUDGET + 8);
  localparam logic [CNT_W-1:0] BUDGET_C = CNT_W'(BUDGET);
  localparam logic [LEN_W-1:0] TEXT_C = LEN_W'(TEXT_MAX);
  localparam logic [LEN_W-1:0] BIG_C  = LEN_W'(BIG_MAX);
  localparam logic [3:0] LAST_IDX = 4'(MAGIC_LEN - 1);

  logic [3:0]       prefIdx;
  logic [CNT_W-1:0] budCnt;
  logic [1:0]       lenIdx;
  logic [LEN_W-1:0] lenAcc, clampedLen, skipCnt;
  logic             isBig, isMatch;

  always_comb begin
    if (isBig) clampedLen = (lenAcc > BIG_C)  ? BIG_C  : lenAcc;
    else       clampedLen = (lenAcc > TEXT_C) ? TEXT_C : lenAcc;
  end

  assign prefMatch  = (inData == magicByte(prefIdx));
  assign prefLast   = (prefIdx == LAST_IDX);
  assign tagOk      = (inData >= TAG_FIRST) && (inData <= TAG_LAST);
  assign lenLast    = (lenIdx == 2'd0);
  assign budgetUsed = (budCnt >= BUDGET_C);
  assign clampZero  = (clampedLen == '0);
  assign skipLast   = (skipCnt == LEN_W'(1));
  assign matchHit   = isMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefIdx  <= '0;
      budCnt   <= '0;
      lenIdx   <= '0;
      lenAcc   <= '0;
      skipCnt  <= '0;
      isBig    <= 1'b0;
      isMatch  <= 1'b0;
      doneOut  <= 1'b0;
      foundOut <= 1'b0;
      errOut   <= 1'b0;
      lenOut   <= '0;
    end else begin
      doneOut <= stb.finish;
      if (stb.clr) begin
        prefIdx  <= '0;
        budCnt   <= '0;
        foundOut <= 1'b0;
        errOut   <= 1'b0;
        lenOut   <= '0;
      end
      if (stb.prefAdv) prefIdx <= prefIdx + 4'd1;
      if (stb.tagLoad) begin
        budCnt  <= budCnt + 1'b1;
        isBig   <= (inData == TAG_WIDE);
        isMatch <= (inData == reqTag);
        lenIdx  <= (inData == TAG_WIDE) ? 2'd3 : 2'd1;
        lenAcc  <= '0;
      end
      if (stb.lenShift) begin
        budCnt <= budCnt + 1'b1;
        lenAcc <= {lenAcc[LEN_W-9:0], inData};
        lenIdx <= lenIdx - 2'd1;
      end
      if (stb.skipLoad) skipCnt <= clampedLen;
      if (stb.skipStep) begin
        budCnt  <= budCnt + 1'b1;
        skipCnt <= skipCnt - LEN_W'(1);
      end
      if (stb.finish) begin
        foundOut <= stb.finFound;
        errOut   <= stb.finErr;
        lenOut   <= stb.finFound ? clampedLen : '0;
      end
    end
  end

  // R9
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    budCnt <= BUDGET_C + CNT_W'(4));
  // R3
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> !foundOut && lenOut == '0);
  // R6
  text_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut && foundOut && !isBig |-> lenOut <= TEXT_C);
  // R7
  big_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut && foundOut && isBig |-> lenOut <= BIG_C);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
endmodule

// File: rtl/hdrCtrl.sv
module hdrCtrl import hdrPkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    inValid,
  input  logic    prefMatch,
  input  logic    prefLast,
  input  logic    tagOk,
  input  logic    lenLast,
  input  logic    budgetUsed,
  input  logic    clampZero,
  input  logic    skipLast,
  input  logic    matchHit,
  output logic    inReady,
  output hdrStb_t stb
);
  hdrState_e state, nxt;

  always_comb begin
    stb     = '0;
    inReady = 1'b0;
    nxt     = state;
    case (state)
      S_IDLE: if (startIn) begin
        stb.clr = 1'b1;
        nxt     = S_PREF;
      end
      S_PREF: begin
        inReady = 1'b1;
        if (inValid) begin
          if (!prefMatch) begin
            stb.finish = 1'b1;
            stb.finErr = 1'b1;
            nxt        = S_IDLE;
          end else if (prefLast) nxt = S_TAG;
          else stb.prefAdv = 1'b1;
        end
      end
      S_TAG: begin
        if (budgetUsed) begin
          stb.finish = 1'b1;
          nxt        = S_IDLE;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            if (!tagOk) begin
              stb.finish = 1'b1;
              nxt        = S_IDLE;
            end else begin
              stb.tagLoad = 1'b1;
              nxt         = S_LEN;
            end
          end
        end
      end
      S_LEN: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.lenShift = 1'b1;
          if (lenLast) nxt = S_EVAL;
        end
      end
      S_EVAL: begin
        if (matchHit) begin
          stb.finish   = 1'b1;
          stb.finFound = 1'b1;
          nxt          = S_IDLE;
        end else if (clampZero) nxt = S_TAG;
        else begin
          stb.skipLoad = 1'b1;
          nxt          = S_SKIP;
        end
      end
      S_SKIP: begin
        if (budgetUsed) begin
          stb.finish = 1'b1;
          nxt        = S_IDLE;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            stb.skipStep = 1'b1;
            if (skipLast) nxt = S_TAG;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  // R10
  hold_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !inReady);
  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> state == S_PREF);
endmodule

// File: rtl/bitHdrParser.sv
module bitHdrParser import hdrPkg::*; #(
  parameter int LEN_W    = 32,
  parameter int BUDGET   = 100,
  parameter int TEXT_MAX = 64,
  parameter int BIG_MAX  = 307200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [7:0]       reqTag,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             doneOut,
  output logic             foundOut,
  output logic             errOut,
  output logic [LEN_W-1:0] lenOut
);
  hdrStb_t stb;
  logic prefMatch, prefLast, tagOk, lenLast, budgetUsed, clampZero, skipLast, matchHit;

  hdrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .inValid(inValid),
    .prefMatch(prefMatch), .prefLast(prefLast), .tagOk(tagOk), .lenLast(lenLast),
    .budgetUsed(budgetUsed), .clampZero(clampZero), .skipLast(skipLast),
    .matchHit(matchHit), .inReady(inReady), .stb(stb)
  );

  hdrPath #(.LEN_W(LEN_W), .BUDGET(BUDGET), .TEXT_MAX(TEXT_MAX), .BIG_MAX(BIG_MAX)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .reqTag(reqTag),
    .prefMatch(prefMatch), .prefLast(prefLast), .tagOk(tagOk), .lenLast(lenLast),
    .budgetUsed(budgetUsed), .clampZero(clampZero), .skipLast(skipLast),
    .matchHit(matchHit), .doneOut(doneOut), .foundOut(foundOut), .errOut(errOut),
    .lenOut(lenOut)
  );
endmodule

// File: tb/bitHdrParser_bench.sv
module bitHdrParser_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [7:0] reqTag = 8'h61;
  logic [7:0] inData = 8'h00;
  logic inValid = 1'b0;
  logic inReady, doneOut, foundOut, errOut;
  logic [31:0] lenOut;

  int total = 0;
  int bad = 0;
  logic [7:0] strm [0:511];
  int wp = 0;
  int ptr = 0;
  logic ptrClr = 1'b0;

  always #10 clk = ~clk;

  bitHdrParser u_bitHdrParser (
    .clk(clk), .rstN(rstN), .startIn(startIn), .reqTag(reqTag), .inData(inData),
    .inValid(inValid), .inReady(inReady), .doneOut(doneOut), .foundOut(foundOut),
    .errOut(errOut), .lenOut(lenOut)
  );

  always @(posedge clk) begin
    if (ptrClr) ptr <= 0;
    else if (inValid && inReady) ptr <= ptr + 1;
  end

  function automatic logic [7:0] sigByte(input int i);
    logic [7:0] s [0:12] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                             8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    return s[i];
  endfunction

  function automatic longint clampOf(input logic [7:0] tag, input longint l);
    if (tag == 8'h65) return (l > 307200) ? 307200 : l;
    return (l > 64) ? 64 : l;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic freshStream();
    for (int i = 0; i < 512; i++) strm[i] = 8'($urandom);
    wp = 0;
  endtask

  task automatic putB(input logic [7:0] b);
    if (wp < 512) strm[wp] = b;
    wp++;
  endtask

  task automatic putSig(input int badAt);
    for (int i = 0; i < 13; i++) putB(i == badAt ? sigByte(i) ^ 8'h20 : sigByte(i));
  endtask

  task automatic putSec(input logic [7:0] tag, input longint l);
    putB(tag);
    if (tag == 8'h65) begin
      putB(8'(l >> 24)); putB(8'(l >> 16));
    end
    putB(8'(l >> 8)); putB(8'(l));
    for (longint k = 0; k < clampOf(tag, l) && k < 80; k++) putB(8'($urandom));
  endtask

  // Reference walk: found, err, len, bytes consumed
  task automatic model(input logic [7:0] req, output bit f, output bit e,
                       output longint l, output int p);
    int cnt;
    logic [7:0] tag;
    longint raw;
    f = 0; e = 0; l = 0; p = 0; cnt = 0;
    for (int i = 0; i < 13; i++) begin
      p++;
      if (strm[p-1] != sigByte(i)) begin e = 1; return; end
    end
    forever begin
      if (cnt >= 100) return;
      tag = strm[p]; p++; cnt++;
      if (tag < 8'h61 || tag > 8'h65) return;
      raw = 0;
      for (int n = 0; n < ((tag == 8'h65) ? 4 : 2); n++) begin
        raw = (raw << 8) | longint'(strm[p]); p++; cnt++;
      end
      raw = clampOf(tag, raw);
      if (tag == req) begin f = 1; l = raw; return; end
      for (longint k = 0; k < raw; k++) begin
        if (cnt >= 100) break;
        p++; cnt++;
      end
    end
  endtask

  task automatic runCase(input string rq, input logic [7:0] req);
    bit f, e;
    longint l;
    int p, waited, endPtr;
    model(req, f, e, l, p);
    @(negedge clk);
    reqTag = req; startIn = 1'b1; ptrClr = 1'b1; inValid = 1'b0;
    @(negedge clk);
    startIn = 1'b0; ptrClr = 1'b0;
    chk(!foundOut && !errOut && lenOut == 0, "R2", lenOut, 0);
    waited = 0;
    while (!doneOut && waited < 3000) begin
      inValid = ($urandom % 4) != 0;
      inData = strm[ptr];
      @(negedge clk);
      waited++;
    end
    chk(doneOut == 1'b1, "R11", waited, 0);
    chk(errOut == e, rq, errOut, e);
    chk(foundOut == f, rq, foundOut, f);
    chk(lenOut == l, rq, lenOut, l);
    chk(ptr == p, rq, ptr, p);
    endPtr = ptr;
    inValid = 1'b1; inData = strm[ptr];
    @(negedge clk);
    chk(doneOut == 1'b0, "R11", doneOut, 0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk(inReady == 1'b0 && ptr == endPtr, "R10", ptr, endPtr);
    chk(foundOut == f && lenOut == l, "R11", lenOut, l);
    inValid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sd;
    sd = $urandom(32'd42);
    repeat (4) @(negedge clk);
    // R1
    chk(!doneOut && !foundOut && !errOut && lenOut == 0 && !inReady, "R1", lenOut, 0);
    rstN = 1'b1;
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    // R2: idle takes nothing
    chk(inReady == 1'b0 && ptr == 0, "R2", ptr, 0);
    inValid = 1'b0;

    freshStream(); putSig(-1); putSec(8'h61, 3); putSec(8'h62, 2);
    runCase("R5", 8'h62);
    freshStream(); putSig(6);
    runCase("R3", 8'h61);
    freshStream(); putSig(12);
    runCase("R3", 8'h61);
    freshStream(); putSig(-1); putSec(8'h61, 1); putB(8'h7A);
    runCase("R4", 8'h62);
    freshStream(); putSig(-1); putSec(8'h63, 200);
    runCase("R6", 8'h63);
    freshStream(); putSig(-1); putSec(8'h61, 256); putSec(8'h64, 5);
    runCase("R6", 8'h64);
    freshStream(); putSig(-1); putSec(8'h65, 32'h0010_0000);
    runCase("R7", 8'h65);
    freshStream(); putSig(-1); putSec(8'h65, 307200);
    runCase("R7", 8'h65);
    freshStream(); putSig(-1); putSec(8'h65, 307201);
    runCase("R7", 8'h65);
    freshStream(); putSig(-1); putSec(8'h65, 2); putSec(8'h61, 1);
    runCase("R8", 8'h61);
    freshStream(); putSig(-1); putSec(8'h62, 0); putSec(8'h63, 0); putSec(8'h61, 9);
    runCase("R8", 8'h61);
    freshStream(); putSig(-1); putSec(8'h61, 60); putSec(8'h62, 60);
    runCase("R9", 8'h65);
    freshStream(); putSig(-1); putSec(8'h61, 64); putSec(8'h62, 29); putSec(8'h63, 4);
    runCase("R9", 8'h63);

    for (int c = 0; c < 40; c++) begin
      logic [7:0] tg;
      longint ln;
      int r;
      freshStream();
      putSig(($urandom % 12 == 0) ? int'($urandom % 13) : -1);
      for (int s = 0; s < 1 + int'($urandom % 6); s++) begin
        r = int'($urandom % 20);
        if (r == 0) tg = ($urandom % 2) ? 8'h60 : 8'h66;
        else tg = 8'h61 + 8'($urandom % 5);
        if (tg == 8'h65) ln = ($urandom % 4 == 0) ? longint'($urandom % 32'h0008_0000) : longint'($urandom % 10);
        else ln = ($urandom % 8 == 0) ? longint'($urandom % 65536) : longint'($urandom % 12);
        putSec(tg, ln);
      end
      runCase("R8", 8'h61 + 8'($urandom % 5));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule